// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor core through its power states: full run, nap, a doze excursion out of nap for bus snooping, sleep, and deep sleep with the PLL switched off. Software asks for a target state through a two-bit mode request. The controller then raises a quiescence request toward the system. It enters the low-power state only once the system acknowledges.

While the core naps, the system can drop its acknowledge to pull the core into doze so that it snoops the bus. Raising the acknowledge again returns the core to nap. A wake event leaves any low-power state. From deep sleep, the exit first re-enables the PLL and holds the core idle until the lock indication arrives.

A separate software bit selects half-frequency core clocking. The selection is sampled only when the power state changes, so the clock ratio never moves in the middle of a state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the controller is in run: fetch, snoop, timer clock, functional-unit clock and PLL enables are 1, the quiescence request is 0 and the divide select is 0.
- R2: In run, mode request 2'b01 asks for nap. The controller then enters a pending state (fetch 0, quiescence request 1, other enables 1) and holds it until acknowledge is 1. After that it is in nap: fetch 0, snoop 0, timer clock 1, functional-unit clock 0, PLL 1, quiescence request 1.
- R3: In nap, acknowledge 0 moves the controller to doze, which matches nap with snoop 1. In doze, acknowledge 1 returns it to nap.
- R4: In run, mode request 2'b10 or 2'b11 enters the same pending state and waits for acknowledge. Then comes sleep: all enables 0 except PLL 1, with quiescence request 1.
- R5: In sleep, mode request 2'b11 moves the controller to deep sleep: all enables 0, PLL 0, quiescence request 1.
- R6: Wake in a pending, nap, doze or sleep state returns the controller to run in the next cycle, with the quiescence request 0.
- R7: Wake in deep sleep moves the controller to relock: PLL 1, quiescence request 0, all other enables 0. Relock holds until PLL lock is 1, then the controller goes to run. Wake has no effect during relock.
- R8: Mode request 2'b00 in any low-power state does not change the state, and the outputs stay the same.
- R9: The divide select loads the half-frequency bit only in a cycle where the state changes. Otherwise it holds its value, including across low-power states.
- R10: Wake takes priority over acknowledge and mode request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 2 | Requested mode: 00 run, 01 nap, 10 sleep, 11 deep sleep |
| half_freq_i | input | 1 | Software half-frequency selection |
| qack_i | input | 1 | System acknowledge of the quiescence request |
| wake_i | input | 1 | Wake or interrupt event |
| pll_lock_i | input | 1 | PLL lock indication |
| fetch_en_o | output | 1 | Instruction fetch enable |
| snoop_en_o | output | 1 | Bus snoop enable |
| tb_clk_en_o | output | 1 | Timer and debug clock domain enable |
| fu_clk_en_o | output | 1 | Functional unit clock enable |
| pll_en_o | output | 1 | PLL enable request |
| qreq_o | output | 1 | Quiescence request to the system |
| div_sel_o | output | 1 | Half-frequency clock select |

## Verification
Every output is decoded straight from the state register. A wrong state therefore appears on the enable and request pins in the cycle after the faulty transition. A lost doze excursion shows as snoop staying 0, a skipped relock as fetch returning while the PLL has not locked, and a premature entry as enables falling while acknowledge is still 0. A divide select that is not held shows as a change of the select in a cycle without any change of the enable pattern. The bench runs a reference model alongside the design and compares all seven outputs every cycle, so each such fault is reported at its first cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        REQ_RUN   = 2'b00,
        REQ_NAP   = 2'b01,
        REQ_SLEEP = 2'b10,
        REQ_DEEP  = 2'b11
    } mode_req_e;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_NAP_PND = 3'd1,
        PS_SLP_PND = 3'd2,
        PS_NAP     = 3'd3,
        PS_DOZE    = 3'd4,
        PS_SLEEP   = 3'd5,
        PS_DEEP    = 3'd6,
        PS_RELOCK  = 3'd7
    } pstate_e;

    typedef struct packed {
        logic fetch;
        logic snoop;
        logic tb_clk;
        logic fu_clk;
        logic pll;
        logic qreq;
    } pwr_ctl_t;

    function automatic pwr_ctl_t ctl_pack(input logic f, input logic s, input logic t,
                                          input logic u, input logic p, input logic q);
        pwr_ctl_t c;
        c.fetch  = f;
        c.snoop  = s;
        c.tb_clk = t;
        c.fu_clk = u;
        c.pll    = p;
        c.qreq   = q;
        return c;
    endfunction

    function automatic logic is_low_power(input pstate_e s);
        return (s == PS_NAP) || (s == PS_DOZE) || (s == PS_SLEEP) || (s == PS_DEEP);
    endfunction
endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_req_i,
    input  logic              qack_i,
    input  logic              wake_i,
    input  logic              pll_lock_i,
    output pstate_e           state_o,
    output logic              boundary_o
);
    pstate_e st_q, st_d;
    mode_req_e req;

    assign req = mode_req_e'(mode_req_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_RUN: begin
                if (req == REQ_NAP)                             st_d = PS_NAP_PND;
                else if (req == REQ_SLEEP || req == REQ_DEEP)   st_d = PS_SLP_PND;
            end
            PS_NAP_PND: begin
                if (wake_i)      st_d = PS_RUN;
                else if (qack_i) st_d = PS_NAP;
            end
            PS_SLP_PND: begin
                if (wake_i)      st_d = PS_RUN;
                else if (qack_i) st_d = PS_SLEEP;
            end
            PS_NAP: begin
                if (wake_i)       st_d = PS_RUN;
                else if (!qack_i) st_d = PS_DOZE;
            end
            PS_DOZE: begin
                if (wake_i)      st_d = PS_RUN;
                else if (qack_i) st_d = PS_NAP;
            end
            PS_SLEEP: begin
                if (wake_i)                st_d = PS_RUN;
                else if (req == REQ_DEEP)  st_d = PS_DEEP;
            end
            PS_DEEP: begin
                if (wake_i) st_d = PS_RELOCK;
            end
            PS_RELOCK: begin
                if (pll_lock_i) st_d = PS_RUN;
            end
            default: st_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PS_RUN;
        else     st_q <= st_d;
    end

    assign state_o    = st_q;
    assign boundary_o = (st_d != st_q);

    // R2 / R4: a low-power state is entered only after acknowledge was seen
    assert_entry_needs_qack_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q == PS_NAP) && $past(st_q) == PS_NAP_PND) |-> $past(qack_i));
    assert_sleep_needs_qack_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == PS_SLEEP) |-> $past(qack_i));
    // R7: deep sleep never returns to run without the relock step
    assert_no_direct_deep_exit_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == PS_DEEP) |-> (st_q != PS_RUN));
    assert_relock_waits_lock_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == PS_RELOCK && st_q == PS_RUN) |-> $past(pll_lock_i));
    // R10: wake in a state left by wake always lands in run
    assert_wake_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (wake_i && st_q != PS_RUN && st_q != PS_DEEP && st_q != PS_RELOCK) |=> (st_q == PS_RUN));
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_pkg::*;
(
    input  pstate_e  state_i,
    output pwr_ctl_t ctl_o
);
    always_comb begin
        unique case (state_i)
            PS_RUN:                 ctl_o = ctl_pack(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            PS_NAP_PND, PS_SLP_PND: ctl_o = ctl_pack(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            PS_NAP:                 ctl_o = ctl_pack(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
            PS_DOZE:                ctl_o = ctl_pack(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
            PS_SLEEP:               ctl_o = ctl_pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            PS_DEEP:                ctl_o = ctl_pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            PS_RELOCK:              ctl_o = ctl_pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            default:                ctl_o = ctl_pack(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        endcase
    end

    // R5: with the PLL off nothing downstream may be clocked
    always_comb begin
        if (!ctl_o.pll) begin
            assert_pll_off_quiet_R5: assert (!ctl_o.fu_clk && !ctl_o.tb_clk && !ctl_o.fetch);
        end
    end
    // R2: no fetch while the functional units are gated
    always_comb begin
        if (ctl_o.fetch) begin
            assert_fetch_needs_fu_R2: assert (ctl_o.fu_clk);
        end
    end
    // R6: the quiescence request is only held in a low-power or pending state
    always_comb begin
        if (is_low_power(state_i)) begin
            assert_qreq_in_low_power_R6: assert (ctl_o.qreq);
        end
    end
endmodule

// File: rtl/pwr_div_ctl.sv
module pwr_div_ctl (
    input  logic clk,
    input  logic rst,
    input  logic boundary_i,
    input  logic half_req_i,
    output logic div_sel_o
);
    logic div_q;

    always_ff @(posedge clk) begin
        if (rst)             div_q <= 1'b0;
        else if (boundary_i) div_q <= half_req_i;
    end

    assign div_sel_o = div_q;

    // R9: the select only moves at a state boundary
    assert_div_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(boundary_i) |-> $stable(div_q));
    assert_div_load_R9: assert property (@(posedge clk) disable iff (rst)
        boundary_i |=> (div_q == $past(half_req_i)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_req_i,
    input  logic              half_freq_i,
    input  logic              qack_i,
    input  logic              wake_i,
    input  logic              pll_lock_i,
    output logic              fetch_en_o,
    output logic              snoop_en_o,
    output logic              tb_clk_en_o,
    output logic              fu_clk_en_o,
    output logic              pll_en_o,
    output logic              qreq_o,
    output logic              div_sel_o
);
    pstate_e  state;
    logic     boundary;
    pwr_ctl_t ctl;

    pwr_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_req_i (mode_req_i),
        .qack_i     (qack_i),
        .wake_i     (wake_i),
        .pll_lock_i (pll_lock_i),
        .state_o    (state),
        .boundary_o (boundary)
    );

    pwr_out_decode u_dec (
        .state_i (state),
        .ctl_o   (ctl)
    );

    pwr_div_ctl u_div (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (boundary),
        .half_req_i (half_freq_i),
        .div_sel_o  (div_sel_o)
    );

    assign fetch_en_o  = ctl.fetch;
    assign snoop_en_o  = ctl.snoop;
    assign tb_clk_en_o = ctl.tb_clk;
    assign fu_clk_en_o = ctl.fu_clk;
    assign pll_en_o    = ctl.pll;
    assign qreq_o      = ctl.qreq;

    // R3: snoop comes back in doze while the core stays halted
    assert_doze_snoops_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DOZE) |-> (snoop_en_o && !fetch_en_o && !fu_clk_en_o));
    // R6: a wake while napping drops the quiescence request next cycle
    assert_wake_drops_qreq_R6: assert property (@(posedge clk) disable iff (rst)
        (wake_i && (state == PS_NAP || state == PS_DOZE || state == PS_SLEEP)) |=> !qreq_o);
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;
    localparam int WATCHDOG = 50000;

    localparam int M_RUN = 0, M_NPND = 1, M_SPND = 2, M_NAP = 3,
                   M_DOZE = 4, M_SLEEP = 5, M_DEEP = 6, M_RELOCK = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_req = 2'b00;
    logic half = 1'b0, qack = 1'b0, wake = 1'b0, lock = 1'b0;
    logic fetch, snoop, tbc, fuc, pll, qreq, div;

    int errors = 0;
    int checks = 0;
    int m_st = M_RUN;
    logic m_div = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst(rst), .mode_req_i(mode_req), .half_freq_i(half),
        .qack_i(qack), .wake_i(wake), .pll_lock_i(lock),
        .fetch_en_o(fetch), .snoop_en_o(snoop), .tb_clk_en_o(tbc),
        .fu_clk_en_o(fuc), .pll_en_o(pll), .qreq_o(qreq), .div_sel_o(div)
    );

    function automatic int model_next(int s, logic [1:0] m, logic q, logic w, logic l);
        case (s)
            M_RUN:    return (m == 2'b01) ? M_NPND : (m[1] ? M_SPND : M_RUN);
            M_NPND:   return w ? M_RUN : (q ? M_NAP : M_NPND);
            M_SPND:   return w ? M_RUN : (q ? M_SLEEP : M_SPND);
            M_NAP:    return w ? M_RUN : (!q ? M_DOZE : M_NAP);
            M_DOZE:   return w ? M_RUN : (q ? M_NAP : M_DOZE);
            M_SLEEP:  return w ? M_RUN : ((m == 2'b11) ? M_DEEP : M_SLEEP);
            M_DEEP:   return w ? M_RELOCK : M_DEEP;
            default:  return l ? M_RUN : M_RELOCK;
        endcase
    endfunction

    // {fetch, snoop, tb, fu, pll, qreq}
    function automatic logic [5:0] model_out(int s);
        case (s)
            M_RUN:          return 6'b111110;
            M_NPND, M_SPND: return 6'b011111;
            M_NAP:          return 6'b001011;
            M_DOZE:         return 6'b011011;
            M_SLEEP:        return 6'b000011;
            M_DEEP:         return 6'b000001;
            default:        return 6'b000010;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            M_RUN:          return "R1/R6";
            M_NPND, M_NAP:  return "R2";
            M_DOZE:         return "R3";
            M_SPND, M_SLEEP:return "R4";
            M_DEEP:         return "R5";
            default:        return "R7";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [5:0] got, exp;
        got = {fetch, snoop, tbc, fuc, pll, qreq};
        exp = model_out(m_st);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s state %0d outputs: actual=%b expected=%b", tag, m_st, got, exp);
        end
        checks++;
        if (div !== m_div) begin
            errors++;
            $display("FAIL R9 divide select: actual=%b expected=%b", div, m_div);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic h, input logic q,
                        input logic w, input logic l, input string tag);
        int nx;
        @(negedge clk);
        mode_req = m; half = h; qack = q; wake = w; lock = l;
        @(posedge clk);
        nx = model_next(m_st, m, q, w, l);
        if (nx != m_st) m_div = h;
        m_st = nx;
        #1;
        compare((tag == "") ? tag_of(m_st) : tag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1");

        // R2: nap request waits for acknowledge
        step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        // R3: doze excursion and return
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        // R8: run request ignored in nap; R9: select held while nap holds
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        // R6: wake from nap
        step(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        // R4 / R5 / R7: sleep, deep sleep, relock
        step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        step(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        step(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        step(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        step(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        // R10: wake and acknowledge together in the pending state
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        // R10: wake beats deep request in sleep
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        step(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "R10");

        // constrained random: acknowledge tends to follow the request
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic [1:0] m;
            logic q, w, l, h;
            m = 2'($urandom % 4);
            if ($urandom % 3 == 0) m = 2'b00;
            q = qreq ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
            w = ($urandom % 10 == 0);
            l = ($urandom % 3 == 0);
            h = 1'($urandom % 2);
            step(m, h, q, w, l, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule